// File: doc/BRIEF.md
# Interrupt Flag and Mask Controller

This block gathers single-cycle event pulses from six interrupt sources into a set of pending flags. The sources are an external pin, a timer input capture, two timer compare matches (A and B), a 16-bit timer overflow and an 8-bit timer overflow. Each source has its own enable bit in a mask. A global enable qualifies every pending request. The block picks one enabled pending source and presents it to a CPU core as a request with a fixed vector address. When the core enters the handler it asserts an acknowledge, and that clears the presented flag.

Software reaches the masks and flags through a small register port with four byte-wide addresses. Reads are combinational. A flag can be cleared in three ways: by writing a one to its bit, by the acknowledge, or by pin level mode. While the pin is configured for level sensing, its flag is held at zero.

Top module: `irq_flag_mask`

## Requirements
- R1: An event pulse on any source input sets that source's flag at the next clock edge. Timer flags read at address 1 in bit positions 7 (16-bit overflow), 6 (compare A), 5 (compare B), 3 (capture) and 1 (8-bit overflow). The pin flag reads at address 3, bit 6.
- R2: `irqReq` is high only when `globalEn` is one and at least one source has both its flag and its mask bit set.
- R3: An acknowledge given while `irqReq` is high clears only the flag of the source whose vector is being presented. All other flags keep their state.
- R4: Writing a one to a flag bit (address 1 or address 3) clears that flag. Writing a zero leaves it unchanged, and no write can set a flag.
- R5: While `pinLevel` is one, the pin flag reads as zero and gives no request. A pin event in that mode is not latched, so the flag is still zero after `pinLevel` returns to zero.
- R6: The vector addresses are 0x001 for the pin, 0x003 for capture, 0x004 for compare A, 0x005 for compare B, 0x006 for the 16-bit overflow and 0x007 for the 8-bit overflow.
- R7: When several enabled flags are pending, the source with the lowest vector address is presented.
- R8: The timer mask at address 0 uses the same bit positions as the timer flags. The pin mask is bit 6 of address 2. Every other bit at addresses 0 to 3 is reserved: it ignores writes and reads as zero. The writable mask bits read back the value last written.
- R9: After reset, all masks and all flags are zero and `irqReq` is low.
- R10: An event that arrives in the same cycle as a write-one-to-clear or an acknowledge of that same source leaves its flag set.
- R11: `irqReq` and `irqVector` follow the flags, masks and `globalEn` in the same cycle. After the acknowledge of the only pending source, `irqReq` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtPin | input | 1 | External pin event pulse |
| evtCapture | input | 1 | Input capture event pulse |
| evtCmpA | input | 1 | Compare A match pulse |
| evtCmpB | input | 1 | Compare B match pulse |
| evtOvf16 | input | 1 | 16-bit timer overflow pulse |
| evtOvf8 | input | 1 | 8-bit timer overflow pulse |
| pinLevel | input | 1 | Pin configured for level sensing |
| globalEn | input | 1 | Global interrupt enable |
| regAddr | input | 2 | Register address (0 timer mask, 1 timer flags, 2 pin mask, 3 pin flag) |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| irqAck | input | 1 | Core has entered the presented handler |
| irqReq | output | 1 | Interrupt request to the core |
| irqVector | output | VEC_W | Vector address of the presented source |

## Verification
The hardest case to reach is a clear that lands in the same cycle as a fresh event of the same source. The bench lines up a write-one-to-clear, and separately an acknowledge, with an event pulse in one cycle, then reads the flag back. Priority and selective acknowledge are checked by sweeping all 63 non-empty patterns of pending sources. For each pattern the bench walks the acknowledge chain down to an idle request and reads the flag registers after every step. The mask and enable gating is swept across all 64 mask settings with the global enable both off and on.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC = 6;
  localparam int REG_W = 8;
  localparam int ADDR_W = 2;

  // Source index order equals priority order (lowest vector first).
  localparam int SRC_PIN  = 0;
  localparam int SRC_CAP  = 1;
  localparam int SRC_CMPA = 2;
  localparam int SRC_CMPB = 3;
  localparam int SRC_OVF16 = 4;
  localparam int SRC_OVF8 = 5;

  // Bit positions inside the timer mask and timer flag registers.
  localparam int BIT_OVF16 = 7;
  localparam int BIT_CMPA  = 6;
  localparam int BIT_CMPB  = 5;
  localparam int BIT_CAP   = 3;
  localparam int BIT_OVF8  = 1;
  localparam int PIN_BIT   = 6;

  localparam logic [ADDR_W-1:0] ADDR_TMASK = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_TFLAG = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_PMASK = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_PFLAG = 2'd3;

  typedef logic [NUM_SRC-1:0] srcVec_t;

  typedef struct packed {
    srcVec_t clrVec;
    logic    timerMaskWr;
    logic    pinMaskWr;
  } ctrlStrobe_t;

  function automatic logic [REG_W-1:0] packTimer(srcVec_t s);
    logic [REG_W-1:0] b;
    b = '0;
    b[BIT_OVF16] = s[SRC_OVF16];
    b[BIT_CMPA]  = s[SRC_CMPA];
    b[BIT_CMPB]  = s[SRC_CMPB];
    b[BIT_CAP]   = s[SRC_CAP];
    b[BIT_OVF8]  = s[SRC_OVF8];
    return b;
  endfunction

  function automatic srcVec_t unpackTimer(logic [REG_W-1:0] b);
    srcVec_t s;
    s = '0;
    s[SRC_OVF16] = b[BIT_OVF16];
    s[SRC_CMPA]  = b[BIT_CMPA];
    s[SRC_CMPB]  = b[BIT_CMPB];
    s[SRC_CAP]   = b[BIT_CAP];
    s[SRC_OVF8]  = b[BIT_OVF8];
    return s;
  endfunction
endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int VEC_W = 12,
  parameter int PIN_VEC = 1,
  parameter int TMR_VEC_BASE = 3
) (
  input  srcVec_t               flags,
  input  srcVec_t               mask,
  input  logic                  globalEn,
  input  logic                  irqAck,
  input  logic                  regWrEn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [REG_W-1:0]      regWrData,
  output logic                  irqReq,
  output logic [VEC_W-1:0]      irqVector,
  output ctrlStrobe_t           strobe
);
  srcVec_t pending;
  srcVec_t selOneHot;
  srcVec_t ackClr;
  srcVec_t timerClr;
  srcVec_t pinClr;
  logic    timerFlagWr;
  logic    pinFlagWr;

  function automatic logic [VEC_W-1:0] vecOf(int i);
    if (i == SRC_PIN) return VEC_W'(PIN_VEC);
    return VEC_W'(TMR_VEC_BASE + i - 1);
  endfunction

  assign pending   = flags & mask & {NUM_SRC{globalEn}};
  // Isolate the lowest set bit: lowest index has the lowest vector.
  assign selOneHot = pending & srcVec_t'(~pending + srcVec_t'(1));
  assign irqReq    = |pending;

  always_comb begin
    irqVector = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (selOneHot[i]) irqVector = irqVector | vecOf(i);
    end
  end

  assign timerFlagWr = regWrEn && (regAddr == ADDR_TFLAG);
  assign pinFlagWr   = regWrEn && (regAddr == ADDR_PFLAG);
  assign ackClr      = irqAck ? selOneHot : '0;
  assign timerClr    = timerFlagWr ? unpackTimer(regWrData) : '0;
  assign pinClr      = (pinFlagWr && regWrData[PIN_BIT]) ? srcVec_t'(1 << SRC_PIN) : '0;

  assign strobe.clrVec      = ackClr | timerClr | pinClr;
  assign strobe.timerMaskWr = regWrEn && (regAddr == ADDR_TMASK);
  assign strobe.pinMaskWr   = regWrEn && (regAddr == ADDR_PMASK);
endmodule

// File: rtl/irq_dp.sv
module irq_dp
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  srcVec_t           events,
  input  logic              pinLevel,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output srcVec_t           flags,
  output srcVec_t           mask,
  output logic [REG_W-1:0]  regRdData
);
  srcVec_t flagQ;
  srcVec_t flagNext;
  srcVec_t maskQ;
  srcVec_t maskWrVal;
  srcVec_t levelKill;

  assign levelKill = pinLevel ? srcVec_t'(1 << SRC_PIN) : '0;
  assign maskWrVal = unpackTimer(regWrData);

  always_comb begin
    // A new event takes precedence over any clear in the same cycle.
    flagNext = events | (flagQ & ~strobe.clrVec);
    flagNext = flagNext & ~levelKill;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= '0;
      maskQ <= '0;
    end else begin
      flagQ <= flagNext;
      if (strobe.timerMaskWr) begin
        for (int i = 0; i < NUM_SRC; i++) begin
          if (i != SRC_PIN) maskQ[i] <= maskWrVal[i];
        end
      end
      if (strobe.pinMaskWr) maskQ[SRC_PIN] <= regWrData[PIN_BIT];
    end
  end

  assign flags = flagQ & ~levelKill;
  assign mask  = maskQ;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_TMASK: regRdData = packTimer(maskQ);
      ADDR_TFLAG: regRdData = packTimer(flags);
      ADDR_PMASK: regRdData[PIN_BIT] = maskQ[SRC_PIN];
      default:    regRdData[PIN_BIT] = flags[SRC_PIN];
    endcase
  end
endmodule

// File: rtl/irq_flag_mask.sv
module irq_flag_mask
  import irq_pkg::*;
#(
  parameter int VEC_W = 12,
  parameter int PIN_VEC = 1,
  parameter int TMR_VEC_BASE = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtPin,
  input  logic              evtCapture,
  input  logic              evtCmpA,
  input  logic              evtCmpB,
  input  logic              evtOvf16,
  input  logic              evtOvf8,
  input  logic              pinLevel,
  input  logic              globalEn,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              irqAck,
  output logic              irqReq,
  output logic [VEC_W-1:0]  irqVector
);
  srcVec_t     events;
  srcVec_t     flags;
  srcVec_t     mask;
  ctrlStrobe_t strobe;

  always_comb begin
    events = '0;
    events[SRC_PIN]   = evtPin;
    events[SRC_CAP]   = evtCapture;
    events[SRC_CMPA]  = evtCmpA;
    events[SRC_CMPB]  = evtCmpB;
    events[SRC_OVF16] = evtOvf16;
    events[SRC_OVF8]  = evtOvf8;
  end

  irq_ctrl #(
    .VEC_W(VEC_W), .PIN_VEC(PIN_VEC), .TMR_VEC_BASE(TMR_VEC_BASE)
  ) u_ctrl (
    .flags(flags), .mask(mask), .globalEn(globalEn), .irqAck(irqAck),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .irqReq(irqReq), .irqVector(irqVector), .strobe(strobe)
  );

  irq_dp u_dp (
    .clk(clk), .rstN(rstN), .events(events), .pinLevel(pinLevel),
    .strobe(strobe), .regAddr(regAddr), .regWrData(regWrData),
    .flags(flags), .mask(mask), .regRdData(regRdData)
  );
endmodule

// File: rtl/irq_flag_mask_chk.sv
module irq_flag_mask_chk #(
  parameter int VEC_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             evtPin,
  input logic             evtCapture,
  input logic             evtCmpA,
  input logic             evtCmpB,
  input logic             evtOvf16,
  input logic             evtOvf8,
  input logic             pinLevel,
  input logic             globalEn,
  input logic [1:0]       regAddr,
  input logic [7:0]       regRdData,
  input logic             irqAck,
  input logic             irqReq,
  input logic [VEC_W-1:0] irqVector
);
  logic anyEvt;
  assign anyEvt = evtPin | evtCapture | evtCmpA | evtCmpB | evtOvf16 | evtOvf8;

  p_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |-> !irqReq);

  p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && irqAck && !anyEvt) |=> (!irqReq || irqVector != $past(irqVector)));

  p_level_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pinLevel && regAddr == 2'd3) |-> regRdData == 8'h00);

  p_vec_legal_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (irqVector == VEC_W'(1) || (irqVector >= VEC_W'(3) && irqVector <= VEC_W'(7))));

  p_reserved_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd0 || regAddr == 2'd1) |-> (regRdData[4] == 1'b0 && regRdData[2] == 1'b0 && regRdData[0] == 1'b0));

  p_event_sets_r1: assert property (@(posedge clk) disable iff (!rstN)
    evtCmpA |=> (regAddr != 2'd1 || regRdData[6]));
endmodule

bind irq_flag_mask irq_flag_mask_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/sim_irq_flag_mask.sv
module sim_irq_flag_mask;
  localparam int VEC_W = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [5:0] evt = '0;
  logic pinLevel = 1'b0;
  logic globalEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic irqAck = 1'b0;
  logic irqReq;
  logic [VEC_W-1:0] irqVector;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_flag_mask #(.VEC_W(VEC_W)) u0 (
    .clk(clk), .rstN(rstN),
    .evtPin(evt[0]), .evtCapture(evt[1]), .evtCmpA(evt[2]),
    .evtCmpB(evt[3]), .evtOvf16(evt[4]), .evtOvf8(evt[5]),
    .pinLevel(pinLevel), .globalEn(globalEn),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .irqAck(irqAck),
    .irqReq(irqReq), .irqVector(irqVector)
  );

  function automatic int expVec(int idx);
    return (idx == 0) ? 1 : idx + 2;
  endfunction

  function automatic int lowIdx(logic [5:0] p);
    for (int i = 0; i < 6; i++) if (p[i]) return i;
    return -1;
  endfunction

  // Timer byte layout: b7 16-bit ovf(4), b6 cmpA(2), b5 cmpB(3), b3 capture(1), b1 8-bit ovf(5).
  function automatic logic [7:0] tPack(logic [5:0] s);
    return {s[4], s[2], s[3], 1'b0, s[1], 1'b0, s[5], 1'b0};
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] v);
    regAddr = a;
    #1 v = regRdData;
  endtask

  task automatic pulse(input logic [5:0] e);
    @(negedge clk);
    evt = e;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic clearAll();
    wrReg(2'd1, 8'hFF);
    wrReg(2'd3, 8'hFF);
  endtask

  task automatic setMask(input logic [5:0] m);
    wrReg(2'd0, tPack(m));
    wrReg(2'd2, {1'b0, m[0], 6'b0});
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [5:0] rem;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R9: reset state
    for (int a = 0; a < 4; a++) begin
      rdReg(a[1:0], v);
      check(v == 8'h00, "R9", "reset register", v, 0);
    end
    #0 check(irqReq == 1'b0, "R9", "reset irqReq", irqReq, 0);

    // R8: mask layout and reserved bits; R4: writes never set flags
    for (int d = 0; d < 256; d++) begin
      wrReg(2'd0, d[7:0]);
      rdReg(2'd0, v);
      check(v == (d[7:0] & 8'hEA), "R8", "timer mask readback", v, d & 8'hEA);
      wrReg(2'd2, d[7:0]);
      rdReg(2'd2, v);
      check(v == (d[7:0] & 8'h40), "R8", "pin mask readback", v, d & 8'h40);
    end
    wrReg(2'd1, 8'h00);
    rdReg(2'd1, v);
    check(v == 8'h00, "R4", "zero write sets no flag", v, 0);

    // R2 / R11: gating sweep with all flags pending
    pulse(6'h3F);
    for (int m = 0; m < 64; m++) begin
      setMask(m[5:0]);
      for (int g = 0; g < 2; g++) begin
        @(negedge clk);
        globalEn = g[0];
        #1;
        check(irqReq == (g == 1 && m != 0), "R2", "irqReq gating", irqReq, (g == 1 && m != 0));
        if (g == 1 && m != 0)
          check(irqVector == VEC_W'(expVec(lowIdx(m[5:0]))), "R7", "masked priority", irqVector, expVec(lowIdx(m[5:0])));
      end
    end

    // R1 / R3 / R6 / R7 / R11: every pattern, acknowledge chain
    setMask(6'h3F);
    globalEn = 1'b1;
    for (int p = 1; p < 64; p++) begin
      clearAll();
      pulse(p[5:0]);
      rdReg(2'd1, v);
      check(v == tPack(p[5:0]), "R1", "timer flags set", v, tPack(p[5:0]));
      rdReg(2'd3, v);
      check(v == {1'b0, p[0], 6'b0}, "R1", "pin flag set", v, {p[0], 6'b0});
      rem = p[5:0];
      while (rem != 0) begin
        check(irqReq == 1'b1, "R11", "request pending", irqReq, 1);
        check(irqVector == VEC_W'(expVec(lowIdx(rem))), "R6", "vector", irqVector, expVec(lowIdx(rem)));
        @(negedge clk);
        irqAck = 1'b1;
        @(negedge clk);
        irqAck = 1'b0;
        rem = rem & (rem - 6'd1);
        rdReg(2'd1, v);
        check(v == tPack(rem), "R3", "only presented flag cleared", v, tPack(rem));
      end
      check(irqReq == 1'b0, "R11", "request drops after last ack", irqReq, 0);
    end

    // R4: write-one-to-clear
    globalEn = 1'b0;
    pulse(6'h3F);
    wrReg(2'd1, 8'h40);
    rdReg(2'd1, v);
    check(v == 8'hAA, "R4", "clear compare A only", v, 8'hAA);
    wrReg(2'd3, 8'h00);
    rdReg(2'd3, v);
    check(v == 8'h40, "R4", "zero write keeps pin flag", v, 8'h40);
    wrReg(2'd3, 8'h40);
    rdReg(2'd3, v);
    check(v == 8'h00, "R4", "one write clears pin flag", v, 0);

    // R10: event collides with write-one-to-clear
    clearAll();
    @(negedge clk);
    regAddr = 2'd1; regWrData = 8'hFF; regWrEn = 1'b1; evt = 6'b100000;
    @(negedge clk);
    regWrEn = 1'b0; evt = '0;
    rdReg(2'd1, v);
    check(v == 8'h02, "R10", "event wins over write clear", v, 8'h02);

    // R10: event collides with acknowledge
    clearAll();
    globalEn = 1'b1;
    pulse(6'b000100);
    @(negedge clk);
    irqAck = 1'b1; evt = 6'b000100;
    @(negedge clk);
    irqAck = 1'b0; evt = '0;
    #1;
    check(irqReq == 1'b1, "R10", "event wins over ack req", irqReq, 1);
    check(irqVector == VEC_W'(4), "R10", "event wins over ack vector", irqVector, 4);
    clearAll();

    // R5: level mode
    pulse(6'b000001);
    @(negedge clk);
    pinLevel = 1'b1;
    rdReg(2'd3, v);
    check(v == 8'h00, "R5", "level mode reads zero", v, 0);
    check(irqReq == 1'b0, "R5", "level mode no request", irqReq, 0);
    pulse(6'b000001);
    rdReg(2'd3, v);
    check(v == 8'h00, "R5", "level event not latched", v, 0);
    @(negedge clk);
    pinLevel = 1'b0;
    #1;
    rdReg(2'd3, v);
    check(v == 8'h00, "R5", "flag zero after level mode", v, 0);
    check(irqReq == 1'b0, "R5", "no request after level mode", irqReq, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule